// File: doc/BRIEF.md
# Adaptive Line-Size Selector for a Sectored Cache

This block keeps a small 2-bit size code for every sector of a direct-mapped sectored cache, or for every group of consecutive sectors, and adjusts that code on each cache lookup. A sector holds four sublines. A subline counts as "adjacent" if the tag logic finds it valid and already touched in the referenced sector. The tag logic hands over the sector index, the position of the referenced subline and a 4-bit vector of adjacent sublines. The selector then reads the sector's code, works out the next one, and writes it back at the clock edge.

The code tells the refill logic how many sublines to bring in on the next miss in that sector. The choices are a single subline, the aligned pair that holds the reference, or the whole sector. The code grows when the referenced subline and its adjacent sublines together cover a larger aligned unit than the current size. It shrinks when they cover less. The decision uses only what is in the sector now, so no history tables are kept. The current code of whatever sector is on the index input is shown combinationally, so the refill logic can use it in the same cycle.

A parameter lets groups of 2^GROUP_SHIFT consecutive sectors share one code. With GROUP_SHIFT = 3, the table is indexed with the sector index shifted right by three.

Top module: `lsz_tracker`

## Requirements
- R1: Size codes are 2'b00 = one subline (smallest), 2'b01 = aligned pair, 2'b10 = whole sector. `size_code` only ever shows one of these three values.
- R2: After a synchronous reset (`rst` high at a clock edge), every entry reads 2'b00.
- R3: A lookup with `lk_valid` high writes the next code of the referenced entry at that clock edge, and `size_code` shows the new code from then on. Inputs presented while `lk_valid` is low change nothing.
- R4: The update pattern is `lk_adj` OR the one-hot bit of `lk_pos` (bit i = subline i). From 2'b00 the code moves to 2'b01 when both bits of the aligned pair holding the reference are set: bits 1:0 for positions 0 and 1, bits 3:2 for positions 2 and 3. It moves to 2'b01 and no further even if all four bits are set.
- R5: From 2'b01 the code moves to 2'b10 when all four pattern bits are set.
- R6: From 2'b10 the code moves to 2'b01 whenever the pattern is not all ones, even when only the referenced bit is set.
- R7: From 2'b01 the code moves to 2'b00 when the pattern holds only the referenced bit. An adjacent bit at the referenced position adds nothing.
- R8: All other cases hold the code. This covers 2'b10 with a full pattern, 2'b01 with an aligned pair but not a full sector, and 2'b00 without its aligned pair, including a set neighbour in the other pair.
- R9: A lookup changes only the referenced entry. All other entries keep their codes.
- R10: With GROUP_SHIFT = 3, sectors whose indices agree above bit 2 share one code: a lookup in any of them updates the code all of them read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high; clears every code to the smallest size |
| lk_valid | input | 1 | A cache lookup is taking place this cycle |
| lk_sector | input | $clog2(SECTORS) | Sector index of the lookup; also selects which code `size_code` shows |
| lk_pos | input | 2 | Position of the referenced subline inside the sector |
| lk_adj | input | 4 | Adjacent-subline flags, bit i for subline i |
| size_code | output | 2 | Current size code of the entry selected by `lk_sector` |

## Verification
The bench targets the corner cases where a plausible mistake changes a code.

- **Full sector seen from the smallest size.** A design that jumps two steps would show 2'b10 instead of 2'b01.
- **Neighbour in the wrong pair.** A pattern with a set neighbour in the other pair must not grow the code. A design that tests adjacency without alignment would grow it anyway.
- **Shrinking from the whole-sector size.** A lone reference must take the code down one step only, to 2'b01. A design that shrinks by more than one step would fall straight to 2'b00.
- **Adjacent flag at the referenced position.** The bench checks that such a flag is not counted as a neighbour.
- **Ignored lookups, neighbouring entries and grouping.** The bench checks that a lookup with `lk_valid` low is ignored and that neighbouring entries stay untouched. In a grouped instance, the code must be shared exactly across the eight-sector boundary and no further.

// File: rtl/lsz_pkg.sv
package lsz_pkg;

   typedef enum logic [1:0] {
      SZ_ONE  = 2'b00,
      SZ_PAIR = 2'b01,
      SZ_FULL = 2'b10,
      SZ_RSVD = 2'b11
   } size_code_t;

   // Unused encoding is read as the smallest size.
   function automatic size_code_t size_norm(input logic [1:0] raw);
      size_norm = (raw == 2'b11) ? SZ_ONE : size_code_t'(raw);
   endfunction

endpackage

// File: rtl/lsz_pattern.sv
module lsz_pattern #(
   parameter int SUBLINES = 4,
   localparam int POS_W = $clog2(SUBLINES)
) (
   input  logic [POS_W-1:0]    pos,
   input  logic [SUBLINES-1:0] adj,
   output logic [SUBLINES-1:0] pat,
   output logic                pair_ok,
   output logic                full_ok,
   output logic                solo
);

   logic [SUBLINES-1:0] ref_hot;

   generate
      for (genvar i = 0; i < SUBLINES; i++) begin : g_hot
         assign ref_hot[i] = (pos == POS_W'(i));
      end
   endgenerate

   assign pat     = adj | ref_hot;
   assign full_ok = &pat;
   assign solo    = (pat == ref_hot);

   // aligned pair holding the reference
   always_comb begin
      pair_ok = 1'b0;
      for (int p = 0; p < SUBLINES / 2; p++) begin
         if (pos[POS_W-1:1] == (POS_W-1)'(p))
            pair_ok = pat[2*p] & pat[2*p+1];
      end
   end

endmodule

// File: rtl/lsz_next.sv
module lsz_next
   import lsz_pkg::*;
(
   input  size_code_t cur,
   input  logic       pair_ok,
   input  logic       full_ok,
   input  logic       solo,
   output size_code_t nxt
);

   always_comb begin
      nxt = cur;
      unique case (cur)
         SZ_ONE:  nxt = pair_ok ? SZ_PAIR : SZ_ONE;
         SZ_PAIR: begin
            if (full_ok)   nxt = SZ_FULL;
            else if (solo) nxt = SZ_ONE;
            else           nxt = SZ_PAIR;
         end
         SZ_FULL: nxt = full_ok ? SZ_FULL : SZ_PAIR;
         default: nxt = pair_ok ? SZ_PAIR : SZ_ONE;
      endcase
   end

endmodule

// File: rtl/lsz_store.sv
module lsz_store
   import lsz_pkg::*;
#(
   parameter int ENTRIES = 128,
   localparam int ENT_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [ENT_W-1:0] raddr,
   output size_code_t       rd_code,
   input  logic             we,
   input  logic [ENT_W-1:0] waddr,
   input  size_code_t       wdata
);

   logic [ENTRIES-1:0][1:0] code_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         code_q <= '0;
      end else if (we) begin
         for (int e = 0; e < ENTRIES; e++) begin
            if (waddr == ENT_W'(e)) code_q[e] <= wdata;
         end
      end
   end

   assign rd_code = size_norm(code_q[raddr]);

   // R3: a write lands in the addressed entry
   a_r3_write_lands: assert property (@(posedge clk) disable iff (rst)
      we |=> (code_q[$past(waddr)] == $past(wdata)));

   // R9: no write, no change anywhere
   a_r9_idle_stable: assert property (@(posedge clk) disable iff (rst)
      !we |=> $stable(code_q));

endmodule

// File: rtl/lsz_tracker.sv
module lsz_tracker
   import lsz_pkg::*;
#(
   parameter int SECTORS     = 128,
   parameter int GROUP_SHIFT = 0,
   parameter int SUBLINES    = 4,
   localparam int IDX_W   = $clog2(SECTORS),
   localparam int ENTRIES = SECTORS >> GROUP_SHIFT,
   localparam int ENT_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
   localparam int POS_W   = $clog2(SUBLINES)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             lk_valid,
   input  logic [IDX_W-1:0] lk_sector,
   input  logic [1:0]       lk_pos,
   input  logic [3:0]       lk_adj,
   output logic [1:0]       size_code
);

   generate
      if (SUBLINES != 4) begin : g_bad_sub
         $error("lsz_tracker: SUBLINES must be 4");
      end
      if ((1 << IDX_W) != SECTORS) begin : g_bad_sec
         $error("lsz_tracker: SECTORS must be a power of two");
      end
      if (GROUP_SHIFT < 0 || GROUP_SHIFT >= IDX_W) begin : g_bad_grp
         $error("lsz_tracker: GROUP_SHIFT out of range");
      end
   endgenerate

   logic [ENT_W-1:0] ent;

   generate
      if (GROUP_SHIFT == 0) begin : g_per_sector
         assign ent = ENT_W'(lk_sector);
      end else begin : g_grouped
         assign ent = ENT_W'(lk_sector >> GROUP_SHIFT);
      end
   endgenerate

   logic [3:0] pat;
   logic       pair_ok, full_ok, solo;
   size_code_t cur, nxt;

   lsz_pattern #(.SUBLINES(SUBLINES)) u_pat (
      .pos     (POS_W'(lk_pos)),
      .adj     (lk_adj),
      .pat     (pat),
      .pair_ok (pair_ok),
      .full_ok (full_ok),
      .solo    (solo)
   );

   lsz_store #(.ENTRIES(ENTRIES)) u_store (
      .clk     (clk),
      .rst     (rst),
      .raddr   (ent),
      .rd_code (cur),
      .we      (lk_valid),
      .waddr   (ent),
      .wdata   (nxt)
   );

   lsz_next u_next (
      .cur     (cur),
      .pair_ok (pair_ok),
      .full_ok (full_ok),
      .solo    (solo),
      .nxt     (nxt)
   );

   assign size_code = cur;

   // R1: only legal codes reach the refill side
   a_r1_legal_code: assert property (@(posedge clk) disable iff (rst)
      size_code != 2'b11);

   // R4: growth never skips a size
   a_r4_one_step: assert property (@(posedge clk) disable iff (rst)
      (lk_valid && cur == SZ_ONE) |-> (nxt != SZ_FULL));

   // R6: a broken full sector falls to the pair size
   a_r6_full_drop: assert property (@(posedge clk) disable iff (rst)
      (lk_valid && cur == SZ_FULL && !(&pat)) |-> (nxt == SZ_PAIR));

   // R7: a lone reference pattern never grows the code
   a_r7_solo_no_grow: assert property (@(posedge clk) disable iff (rst)
      (lk_valid && solo) |-> (nxt <= cur));

endmodule

// File: tb/tb_lsz_tracker.sv
`timescale 1ns/100ps
module tb_lsz_tracker;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       lk_valid = 1'b0;
   logic       g_valid = 1'b0;
   logic [6:0] lk_sector = '0;
   logic [1:0] lk_pos = '0;
   logic [3:0] lk_adj = '0;
   logic [1:0] code_a, code_g;

   int total = 0;
   int bad = 0;

   always #2.5 clk = ~clk;

   lsz_tracker #(.SECTORS(128), .GROUP_SHIFT(0)) dut (
      .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_sector(lk_sector),
      .lk_pos(lk_pos), .lk_adj(lk_adj), .size_code(code_a));

   lsz_tracker #(.SECTORS(128), .GROUP_SHIFT(3)) dut_grp (
      .clk(clk), .rst(rst), .lk_valid(g_valid), .lk_sector(lk_sector),
      .lk_pos(lk_pos), .lk_adj(lk_adj), .size_code(code_g));

   task automatic look(input int sec, input int pos, input logic [3:0] adj, input bit grp);
      @(negedge clk);
      lk_sector = 7'(sec);
      lk_pos    = 2'(pos);
      lk_adj    = adj;
      if (grp) g_valid = 1'b1; else lk_valid = 1'b1;
      @(negedge clk);
      lk_valid = 1'b0;
      g_valid  = 1'b0;
   endtask

   task automatic peek(input string tag, input int sec, input bit grp, input logic [1:0] exp);
      logic [1:0] act;
      lk_sector = 7'(sec);
      #1;
      act = grp ? code_g : code_a;
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s sector %0d: actual=%b expected=%b", tag, sec, act, exp);
      end
   endtask

   task automatic pulse_reset();
      @(negedge clk);
      rst = 1'b1;
      repeat (2) @(negedge clk);
      rst = 1'b0;
   endtask

   task automatic t_reset();
      pulse_reset();
      peek("R2 reset", 0, 0, 2'b00);
      peek("R2 reset", 5, 0, 2'b00);
      peek("R2 reset", 127, 0, 2'b00);
      peek("R2 reset grp", 120, 1, 2'b00);
   endtask

   task automatic t_grow_shrink();
      look(3, 0, 4'b0010, 0); peek("R4 pair grow", 3, 0, 2'b01);
      look(3, 0, 4'b1110, 0); peek("R5 full grow", 3, 0, 2'b10);
      look(3, 0, 4'b1110, 0); peek("R8 full hold", 3, 0, 2'b10);
      look(3, 2, 4'b0000, 0); peek("R6 one step down", 3, 0, 2'b01);
      look(3, 2, 4'b1000, 0); peek("R8 pair hold", 3, 0, 2'b01);
      look(3, 1, 4'b0000, 0); peek("R7 solo shrink", 3, 0, 2'b00);
      look(3, 1, 4'b0100, 0); peek("R8 misaligned hold", 3, 0, 2'b00);
   endtask

   task automatic t_min_full();
      look(9, 3, 4'b0111, 0); peek("R4 no double step", 9, 0, 2'b01);
   endtask

   task automatic t_solo_self();
      look(10, 2, 4'b1000, 0); peek("R4 upper pair", 10, 0, 2'b01);
      look(10, 1, 4'b0010, 0); peek("R7 self flag", 10, 0, 2'b00);
   endtask

   task automatic t_no_valid();
      @(negedge clk);
      lk_sector = 7'd20; lk_pos = 2'd0; lk_adj = 4'b1111;
      @(negedge clk);
      peek("R3 invalid ignored", 20, 0, 2'b00);
   endtask

   task automatic t_isolation();
      peek("R9 neighbour", 8, 0, 2'b00);
      peek("R9 neighbour", 11, 0, 2'b00);
      peek("R9 kept", 9, 0, 2'b01);
      peek("R1 legal", 2, 0, 2'b00);
   endtask

   task automatic t_group();
      look(17, 0, 4'b0010, 1);
      peek("R10 shared low", 16, 1, 2'b01);
      peek("R10 shared high", 23, 1, 2'b01);
      peek("R10 next group", 24, 1, 2'b00);
      peek("R10 prev group", 15, 1, 2'b00);
      peek("R9 other instance", 17, 0, 2'b00);
      look(22, 2, 4'b1011, 1);
      peek("R10 shared grow", 16, 1, 2'b10);
   endtask

   task automatic t_reset_again();
      pulse_reset();
      peek("R2 re-reset", 3, 0, 2'b00);
      peek("R2 re-reset", 9, 0, 2'b00);
      peek("R2 re-reset", 10, 0, 2'b00);
      peek("R2 re-reset grp", 16, 1, 2'b00);
   endtask

   initial begin
      t_reset();
      t_grow_shrink();
      t_min_full();
      t_solo_self();
      t_no_valid();
      t_isolation();
      t_group();
      t_reset_again();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(5 * 200000);
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule